// File: doc/BRIEF.md
# Shared Page Frame Cache Controller

This block manages a small set of local page frames that stand in front of one or more global backing memories. Up to four processors (or message routers) present requests on independent ports. Each request names a backing memory and a page inside it, and asks either to acquire the page or to give it back. An acquire returns the number of the local frame that holds the page. When the page is not resident, the block first streams the whole page from the chosen memory into a frame and only then replies.

Each frame keeps a count of outstanding holders. An acquire that hits or fills raises the count, and a release lowers it. Replacement picks the least recently used frame among those that nobody holds. A miss that finds every frame held waits until some processor releases a frame. Releases that do not match a held resident page are answered with an error and change nothing.

Top module: `page_cache_mmu`

## Requirements
- R1: After reset the block issues no response and no memory read, and every frame is empty, so the first acquire of any page misses.
- R2: An acquire of a resident page is answered (rsp_valid=1, rsp_err=0, rsp_frame = its frame) in the cycle after it is accepted, with no memory read.
- R3: An acquire of a non-resident page raises mem_req for exactly one cycle with mem_sel/mem_page naming the page. The block then takes PAGE_WORDS beats on mem_rvalid and writes beat b to local word address frame*PAGE_WORDS+b. It answers in the cycle after the last write.
- R4: The frame for a miss is the lowest-numbered empty frame if one exists. Otherwise it is the least recently used frame with a zero holder count, where an acquire hit or a fill counts as a use.
- R5: A frame's holder count rises by one on each acquire hit or fill and falls by one on each accepted release. A frame with a nonzero count is never replaced, and a miss that finds every frame held is not accepted (req_ready stays 0) until a release frees a frame.
- R6: A release of a page that is not resident, or whose holder count is already zero, is answered with rsp_err=1 and changes no frame state.
- R7: Eligible ports are served one per cycle in round-robin order, starting after the port last served. After reset, port 0 is searched first.
- R8: The memory number is part of the page identity: the same page number in two memories occupies two frames.
- R9: While a page fill is in progress no request on any port is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_PORTS | Request present, one bit per port, held until req_ready |
| req_rel | input | N_PORTS | 1 = release, 0 = acquire, per port |
| req_mem | input | N_PORTS*MEM_W | Backing memory number, port p at bits p*MEM_W |
| req_page | input | N_PORTS*PAGE_W | Page number, port p at bits p*PAGE_W |
| req_ready | output | N_PORTS | One-hot accept strobe for the served port |
| rsp_valid | output | 1 | Response strobe |
| rsp_port | output | PORT_W | Port the response belongs to |
| rsp_frame | output | FR_W | Local frame holding the page |
| rsp_err | output | 1 | Release did not match a held resident page |
| mem_req | output | 1 | One-cycle page read request |
| mem_sel | output | MEM_W | Memory to read |
| mem_page | output | PAGE_W | Page to read |
| mem_rvalid | input | 1 | Read data beat valid |
| mem_rdata | input | DATA_W | Read data beat |
| fr_we | output | 1 | Local frame write strobe |
| fr_addr | output | FR_W+OFF_W | Local word address |
| fr_wdata | output | DATA_W | Local write data |

## Verification
A wrong tag or holder count shows up at the ports on the next acquire or release of that page. The symptom is a wrong rsp_frame, a memory read where a hit was due, or an error flag on a legal release. A corrupted recency order is seen only at the next miss with all frames full, as a fill written to the wrong frame addresses. A broken holder count can also evict a held page, and that appears later as a refill. The bench therefore replays access patterns whose victim frames are known in advance, and it checks every fill word's address.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  typedef enum logic {FS_IDLE, FS_LOAD} fill_state_t;

  function automatic int wrap_add(input int idx, input int step, input int n);
    return (idx + step) % n;
  endfunction
endpackage

// File: rtl/mmu_rr_arb.sv
module mmu_rr_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  elig,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] gidx,
  output logic          any
);
  import mmu_pkg::*;
  logic [IW-1:0] ptr;

  function automatic logic [IW:0] pick(input logic [N-1:0] e, input logic [IW-1:0] p);
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = wrap_add(int'(p), k, N);
      if (e[idx]) return {1'b1, IW'(idx)};
    end
    return '0;
  endfunction

  logic [IW:0] sel;
  always_comb begin
    sel   = pick(elig, ptr);
    any   = sel[IW];
    gidx  = sel[IW-1:0];
    grant = any ? (N'(1) << gidx) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (any) ptr <= IW'(wrap_add(int'(gidx), 1, N));
  end

  assert_one_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~elig) == '0));
endmodule

// File: rtl/mmu_tag_store.sv
module mmu_tag_store #(
  parameter int N_PORTS  = 4,
  parameter int N_FRAMES = 4,
  parameter int KEY_W    = 7,
  parameter int REF_W    = 4,
  localparam int FR_W = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_PORTS*KEY_W-1:0] lk_key,
  output logic [N_PORTS-1:0]       lk_hit,
  output logic [N_PORTS*FR_W-1:0]  lk_frame,
  output logic [N_PORTS-1:0]       lk_cnt_zero,
  output logic [N_PORTS-1:0]       lk_cnt_full,
  output logic                     victim_ok,
  output logic [FR_W-1:0]          victim_frame,
  input  logic                     op_acq,
  input  logic                     op_rel,
  input  logic                     op_inst,
  input  logic [FR_W-1:0]          op_frame,
  input  logic [KEY_W-1:0]         op_key
);
  logic             valid [N_FRAMES];
  logic [KEY_W-1:0] tag   [N_FRAMES];
  logic [REF_W-1:0] cnt   [N_FRAMES];
  logic [FR_W-1:0]  rank  [N_FRAMES];   // 0 = most recently used

  for (genvar p = 0; p < N_PORTS; p++) begin : g_lookup
    logic [FR_W-1:0] fr;
    logic            hit;
    always_comb begin
      hit = 1'b0;
      fr  = '0;
      for (int f = 0; f < N_FRAMES; f++)
        if (valid[f] && tag[f] == lk_key[p*KEY_W +: KEY_W]) begin
          hit = 1'b1;
          fr  = FR_W'(f);
        end
    end
    assign lk_hit[p]                 = hit;
    assign lk_frame[p*FR_W +: FR_W]  = fr;
    assign lk_cnt_zero[p]            = (cnt[fr] == '0);
    assign lk_cnt_full[p]            = (&cnt[fr]);
  end

  // victim: lowest empty frame, else oldest frame with no holders
  always_comb begin
    logic            have_inv, have_free;
    logic [FR_W-1:0] best_rank;
    have_inv     = 1'b0;
    have_free    = 1'b0;
    best_rank    = '0;
    victim_frame = '0;
    for (int f = 0; f < N_FRAMES; f++)
      if (!valid[f] && !have_inv) begin
        have_inv     = 1'b1;
        victim_frame = FR_W'(f);
      end
    if (!have_inv)
      for (int f = 0; f < N_FRAMES; f++)
        if (cnt[f] == '0 && (!have_free || rank[f] > best_rank)) begin
          have_free    = 1'b1;
          best_rank    = rank[f];
          victim_frame = FR_W'(f);
        end
    victim_ok = have_inv || have_free;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int f = 0; f < N_FRAMES; f++) begin
        valid[f] <= 1'b0;
        tag[f]   <= '0;
        cnt[f]   <= '0;
        rank[f]  <= FR_W'(f);
      end
    end else begin
      if (op_acq || op_inst)
        for (int g = 0; g < N_FRAMES; g++)
          if (FR_W'(g) == op_frame)       rank[g] <= '0;
          else if (rank[g] < rank[op_frame]) rank[g] <= rank[g] + 1'b1;
      if (op_acq) cnt[op_frame] <= cnt[op_frame] + 1'b1;
      if (op_rel) cnt[op_frame] <= cnt[op_frame] - 1'b1;
      if (op_inst) begin
        valid[op_frame] <= 1'b1;
        tag[op_frame]   <= op_key;
        cnt[op_frame]   <= REF_W'(1);
      end
    end
  end

  assert_victim_unheld_R5: assert property (@(posedge clk) disable iff (!rst_n)
    op_inst |-> (cnt[op_frame] == '0));

  always @(posedge clk)
    if (rst_n)
      for (int a = 0; a < N_FRAMES; a++)
        for (int b = a + 1; b < N_FRAMES; b++)
          assert_unique_tags_R8: assert (!(valid[a] && valid[b] && tag[a] == tag[b]));
endmodule

// File: rtl/mmu_fill.sv
module mmu_fill #(
  parameter int PAGE_WORDS = 4,
  parameter int FR_W       = 2,
  parameter int DATA_W     = 16,
  localparam int OFF_W = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FR_W-1:0]       start_frame,
  input  logic                  mem_rvalid,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic                  busy,
  output logic                  done,
  output logic                  fr_we,
  output logic [FR_W+OFF_W-1:0] fr_addr,
  output logic [DATA_W-1:0]     fr_wdata
);
  import mmu_pkg::*;
  fill_state_t      st;
  logic [OFF_W-1:0] beat;
  logic [FR_W-1:0]  frame;

  function automatic logic is_last(input logic [OFF_W-1:0] b);
    return int'(b) == PAGE_WORDS - 1;
  endfunction

  assign busy     = (st == FS_LOAD);
  assign fr_we    = busy && mem_rvalid;
  assign fr_addr  = {frame, beat};
  assign fr_wdata = mem_rdata;
  assign done     = fr_we && is_last(beat);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= FS_IDLE;
      beat  <= '0;
      frame <= '0;
    end else if (st == FS_IDLE) begin
      if (start) begin
        st    <= FS_LOAD;
        beat  <= '0;
        frame <= start_frame;
      end
    end else if (fr_we) begin
      beat <= beat + 1'b1;
      if (is_last(beat)) st <= FS_IDLE;
    end
  end

  assert_fill_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/page_cache_mmu.sv
module page_cache_mmu #(
  parameter int N_PORTS    = 4,
  parameter int N_FRAMES   = 4,
  parameter int N_MEMS     = 2,
  parameter int PAGE_WORDS = 4,
  parameter int PAGE_W     = 6,
  parameter int DATA_W     = 16,
  parameter int REF_W      = 4,
  localparam int MEM_W  = (N_MEMS > 1) ? $clog2(N_MEMS) : 1,
  localparam int FR_W   = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1,
  localparam int OFF_W  = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 1,
  localparam int PORT_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int KEY_W  = MEM_W + PAGE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_PORTS-1:0]        req_valid,
  input  logic [N_PORTS-1:0]        req_rel,
  input  logic [N_PORTS*MEM_W-1:0]  req_mem,
  input  logic [N_PORTS*PAGE_W-1:0] req_page,
  output logic [N_PORTS-1:0]        req_ready,
  output logic                      rsp_valid,
  output logic [PORT_W-1:0]         rsp_port,
  output logic [FR_W-1:0]           rsp_frame,
  output logic                      rsp_err,
  output logic                      mem_req,
  output logic [MEM_W-1:0]          mem_sel,
  output logic [PAGE_W-1:0]         mem_page,
  input  logic                      mem_rvalid,
  input  logic [DATA_W-1:0]         mem_rdata,
  output logic                      fr_we,
  output logic [FR_W+OFF_W-1:0]     fr_addr,
  output logic [DATA_W-1:0]         fr_wdata
);
  logic [N_PORTS*KEY_W-1:0] keys;
  logic [N_PORTS-1:0]       lk_hit, lk_zero, lk_full, elig;
  logic [N_PORTS*FR_W-1:0]  lk_frame;
  logic                     victim_ok, any, busy, done;
  logic [FR_W-1:0]          victim_frame, g_frame, fill_frame;
  logic [PORT_W-1:0]        gidx, fill_port;
  logic [KEY_W-1:0]         g_key, fill_key;
  logic                     g_rel, g_hit, g_zero;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    assign keys[p*KEY_W +: KEY_W] = {req_mem[p*MEM_W +: MEM_W], req_page[p*PAGE_W +: PAGE_W]};
    assign elig[p] = req_valid[p] && !busy &&
                     (req_rel[p] || (lk_hit[p] ? !lk_full[p] : victim_ok));
  end

  mmu_rr_arb #(.N(N_PORTS)) i_arb (
    .clk(clk), .rst_n(rst_n), .elig(elig), .grant(req_ready), .gidx(gidx), .any(any));

  assign g_rel   = req_rel[gidx];
  assign g_hit   = lk_hit[gidx];
  assign g_zero  = lk_zero[gidx];
  assign g_frame = lk_frame[gidx*FR_W +: FR_W];
  assign g_key   = keys[gidx*KEY_W +: KEY_W];

  // named internal events
  logic ev_acq_hit, ev_rel_ok, ev_rel_err, ev_miss;
  assign ev_acq_hit = any && !g_rel && g_hit;
  assign ev_rel_ok  = any && g_rel && g_hit && !g_zero;
  assign ev_rel_err = any && g_rel && !(g_hit && !g_zero);
  assign ev_miss    = any && !g_rel && !g_hit;

  mmu_tag_store #(.N_PORTS(N_PORTS), .N_FRAMES(N_FRAMES), .KEY_W(KEY_W), .REF_W(REF_W)) i_tags (
    .clk(clk), .rst_n(rst_n), .lk_key(keys), .lk_hit(lk_hit), .lk_frame(lk_frame),
    .lk_cnt_zero(lk_zero), .lk_cnt_full(lk_full),
    .victim_ok(victim_ok), .victim_frame(victim_frame),
    .op_acq(ev_acq_hit), .op_rel(ev_rel_ok), .op_inst(done),
    .op_frame(done ? fill_frame : g_frame), .op_key(fill_key));

  mmu_fill #(.PAGE_WORDS(PAGE_WORDS), .FR_W(FR_W), .DATA_W(DATA_W)) i_fill (
    .clk(clk), .rst_n(rst_n), .start(ev_miss), .start_frame(victim_frame),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .fr_we(fr_we), .fr_addr(fr_addr), .fr_wdata(fr_wdata));

  assign mem_sel  = fill_key[KEY_W-1 -: MEM_W];
  assign mem_page = fill_key[PAGE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_port   <= '0;
      rsp_frame  <= '0;
      rsp_err    <= 1'b0;
      mem_req    <= 1'b0;
      fill_port  <= '0;
      fill_frame <= '0;
      fill_key   <= '0;
    end else begin
      mem_req   <= ev_miss;
      rsp_valid <= ev_acq_hit || ev_rel_ok || ev_rel_err || done;
      if (ev_miss) begin
        fill_port  <= gidx;
        fill_frame <= victim_frame;
        fill_key   <= g_key;
      end
      if (done) begin
        rsp_port  <= fill_port;
        rsp_frame <= fill_frame;
        rsp_err   <= 1'b0;
      end else if (any) begin
        rsp_port  <= gidx;
        rsp_frame <= ev_rel_err ? '0 : g_frame;
        rsp_err   <= ev_rel_err;
      end
    end
  end

  assert_read_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  assert_no_accept_in_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (req_ready == '0));
endmodule

// File: tb/test_page_cache_mmu.sv
module test_page_cache_mmu;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 4;

  logic clk = 0, rst_n = 0;
  logic [3:0]  v = 0, rel = 0, req_ready;
  logic        m  [4];
  logic [5:0]  pg [4];
  logic [3:0]  req_mem;
  logic [23:0] req_page;
  logic        rsp_valid, rsp_err, mem_req, fr_we;
  logic [1:0]  rsp_port, rsp_frame;
  logic [0:0]  mem_sel;
  logic [5:0]  mem_page;
  logic        mem_rvalid = 0;
  logic [15:0] mem_rdata = 0, fr_wdata;
  logic [3:0]  fr_addr;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb
    for (int p = 0; p < 4; p++) begin
      req_mem[p]          = m[p];
      req_page[p*6 +: 6]  = pg[p];
    end

  page_cache_mmu i_page_cache_mmu (
    .clk(clk), .rst_n(rst_n), .req_valid(v), .req_rel(rel), .req_mem(req_mem),
    .req_page(req_page), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_port(rsp_port), .rsp_frame(rsp_frame), .rsp_err(rsp_err),
    .mem_req(mem_req), .mem_sel(mem_sel), .mem_page(mem_page),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .fr_we(fr_we), .fr_addr(fr_addr), .fr_wdata(fr_wdata));

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] word(input int mm, input int pp, input int b);
    return 16'((mm << 12) | (pp << 4) | b);
  endfunction

  task automatic go(input int p, input bit r, input int mm, input int pp);
    m[p] = 1'(mm); pg[p] = 6'(pp); rel[p] = r; v[p] = 1'b1;
  endtask

  // waits for port p's response; serves any fill on the way
  task automatic wait_rsp(input int p, input bit exp_fill, input int exp_frame,
                          input bit exp_err, input string req);
    bit filled = 0;
    for (int guard = 0; guard < 100; guard++) begin
      @(negedge clk);
      mem_rvalid = 0;
      if (mem_req) begin
        filled = 1;
        check(mem_sel == 1'(m[p]) && mem_page == pg[p], "R3", "read target",
              int'({mem_sel, mem_page}), int'({m[p], pg[p]}));
        for (int b = 0; b < PW; b++) begin
          if (b > 0) @(negedge clk);
          mem_rvalid = 1; mem_rdata = word(m[p], pg[p], b);
          #1;
          check(fr_we && fr_addr == 4'(exp_frame*PW + b) && fr_wdata == mem_rdata,
                "R3", "fill write addr", int'(fr_addr), exp_frame*PW + b);
          check(req_ready == 0, "R9", "accept during fill", int'(req_ready), 0);
        end
      end
      if (rsp_valid && rsp_port == 2'(p)) begin
        check(filled == exp_fill, exp_fill ? "R3" : "R2", "memory read used", filled, exp_fill);
        check(rsp_err == exp_err, req, "rsp_err", rsp_err, exp_err);
        if (!exp_err) check(rsp_frame == 2'(exp_frame), req, "rsp_frame", rsp_frame, exp_frame);
        v[p] = 0;
        return;
      end
    end
    check(0, req, "response timeout", 0, 1);
    v[p] = 0;
  endtask

  task automatic op(input int p, input bit r, input int mm, input int pp,
                    input bit fill, input int fr, input bit err, input string req);
    @(negedge clk);
    go(p, r, mm, pp);
    wait_rsp(p, fill, fr, err, req);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(rsp_valid == 0 && mem_req == 0, "R1", "idle after reset", rsp_valid, 0);
  endtask

  task automatic t_fill_empty;   // frames filled in order, R8 same page other memory
    op(0, 0, 0, 5,  1, 0, 0, "R1"); op(0, 1, 0, 5,  0, 0, 0, "R5");
    op(1, 0, 0, 6,  1, 1, 0, "R4"); op(1, 1, 0, 6,  0, 1, 0, "R5");
    op(2, 0, 1, 5,  1, 2, 0, "R8"); op(2, 1, 1, 5,  0, 2, 0, "R5");
    op(3, 0, 0, 7,  1, 3, 0, "R4"); op(3, 1, 0, 7,  0, 3, 0, "R5");
  endtask

  task automatic t_hit_and_lru;
    op(0, 0, 0, 5,  0, 0, 0, "R2"); op(0, 1, 0, 5,  0, 0, 0, "R5");
    op(1, 0, 1, 9,  1, 1, 0, "R4"); op(1, 1, 1, 9,  0, 1, 0, "R5");
    op(2, 0, 1, 5,  0, 2, 0, "R2");            // hold f2
    op(3, 0, 0, 20, 1, 3, 0, "R4");            // f2 held, LRU free is f3
    op(0, 0, 0, 5,  0, 0, 0, "R2");
    op(1, 0, 1, 9,  0, 1, 0, "R2");            // all four held
  endtask

  task automatic t_all_held;
    @(negedge clk); go(0, 0, 0, 30);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(req_ready[0] == 0 && mem_req == 0, "R5", "miss accepted while all held", int'(req_ready[0]), 0);
    end
    go(1, 1, 1, 9);
    wait_rsp(1, 0, 1, 0, "R5");
    wait_rsp(0, 1, 1, 0, "R5");                 // only freed frame f1
  endtask

  task automatic t_release_errors;
    op(0, 0, 0, 5,  0, 0, 0, "R2");            // f0 count 2
    op(0, 1, 0, 5,  0, 0, 0, "R5");
    op(0, 1, 0, 5,  0, 0, 0, "R5");
    op(0, 1, 0, 5,  0, 0, 1, "R6");            // count already zero
    op(0, 1, 0, 5,  0, 0, 1, "R6");            // still zero: unchanged
    op(2, 1, 1, 9,  0, 0, 1, "R6");            // evicted page
    op(0, 0, 0, 5,  0, 0, 0, "R6");            // still resident, hit
  endtask

  task automatic t_fill_blocks;
    op(2, 1, 1, 5,  0, 2, 0, "R5");
    op(3, 1, 0, 20, 0, 3, 0, "R5");
    op(0, 1, 0, 5,  0, 0, 0, "R5");            // free: f2 (oldest), f3, f0
    @(negedge clk); go(0, 0, 0, 40);
    @(posedge clk); #1 go(2, 1, 1, 63);
    wait_rsp(0, 1, 2, 0, "R4");
    wait_rsp(2, 0, 0, 1, "R9");
  endtask

  task automatic rr_expect(input int n, input int o0, input int o1, input int o2, input int o3);
    int ord [4];
    int k = 0;
    ord = '{o0, o1, o2, o3};
    for (int guard = 0; guard < 40 && k < n; guard++) begin
      @(negedge clk);
      if (rsp_valid) begin
        check(rsp_port == 2'(ord[k]), "R7", "service order", rsp_port, ord[k]);
        v[rsp_port] = 0;
        k++;
      end
    end
    check(k == n, "R7", "responses seen", k, n);
  endtask

  task automatic t_round_robin;
    @(negedge clk); go(3, 1, 1, 63); rr_expect(1, 3, 0, 0, 0);
    @(negedge clk); for (int p = 0; p < 4; p++) go(p, 1, 1, 63);
    rr_expect(4, 0, 1, 2, 3);
    @(negedge clk); go(1, 1, 1, 63); rr_expect(1, 1, 0, 0, 0);
    @(negedge clk); go(0, 1, 1, 63); go(3, 1, 1, 63);
    rr_expect(2, 3, 0, 0, 0);
  endtask

  initial begin
    for (int p = 0; p < 4; p++) begin m[p] = 0; pg[p] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fill_empty();
    t_hit_and_lru();
    t_all_held();
    t_release_errors();
    t_fill_blocks();
    t_round_robin();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule